// File: doc/BRIEF.md
# Memory Attribute Access Checker

This block examines one memory reference per clock and decides, from the reference's kind, its speculation flavor and the attribute of the page it targets, what happens to it. There are three possible outcomes. The reference may go ahead. It may be turned into a deferred result, where the not-a-value indicator is written to the target register and the access itself is dropped. Or it may stop with a fault code. The verdict is registered and appears exactly one cycle after the reference is presented.

The checker sits beside the load/store pipeline after translation. Translation supplies the page attribute. A neighbouring check supplies a vector of lower-priority fault flags, and a deferral mask says which of those flags a speculative reference may defer. An option input tells the block whether this implementation supports 10-byte float accesses to pages that are not write-back cacheable.

Top module: `memAttrChecker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, resValid is 0 and resCode is 0.
- R2: Every result is registered. A reference presented with refValid=1 produces resValid=1 and its verdict one clock later. A cycle with refValid=0 produces resValid=0 and resCode=0 one clock later.
- R3: A speculative reference targeting a page with attribute 2 (NaT page) is deferred with code 1. A speculative reference is a load (kind 1) or a 10-byte float load (kind 6) with flavor 3 (control-speculative) or flavor 4 (speculative-advanced). A deferred reference has resNatWrite=1 and resSideEffect=1, so post-increment is still performed.
- R4: Every non-speculative reference to a NaT page gets code 2 (NaT page consumption) and resSideEffect=0. This covers instruction fetch (kind 0), loads with flavor 0, 1 or 2, store (2), semaphore (3), exchange (4), compare-exchange (5) and 10-byte float store (7).
- R5: A non-speculative 10-byte float load or store (kind 6 or 7) to a page that is not write-back (attribute 0) gets code 3 (unsupported data reference) when wideOk=0. When wideOk=1 it proceeds.
- R6: A speculative 10-byte float load to a page that is not write-back and not a NaT page is always deferred (code 1), whatever the value of wideOk.
- R7: Exchange and compare-exchange get code 3 on an uncacheable page (attribute 1 or 3) whatever wideOk is. On a write-back page, with no lower fault flagged, they proceed with code 0.
- R8: NaT-page handling outranks the unsupported check. For example, a normal 10-byte float load to a NaT page with wideOk=0 gets code 2. Both of these checks outrank the lower-priority fault flags.
- R9: When a lower-priority fault bit is set and no higher check applies, the outcome depends on the flavor. A non-speculative reference gets code 4 (lower fault). A speculative reference gets code 4 if any set bit is missing from deferMask, and otherwise code 1. The same rule decides a speculative reference to a NaT page.
- R10: Attribute value 3 is treated as uncacheable. Flavor values 5 to 7 are treated as normal. The flavor is ignored for every kind other than 1 and 6.
- R11: Code encoding is 0 proceed, 1 deferred, 2 NaT page consumption, 3 unsupported data reference, 4 lower fault. resProceed is 1 exactly for code 0. resNatWrite is 1 exactly for code 1. resSideEffect is 1 exactly for codes 0 and 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| refValid | input | 1 | a reference is presented this cycle |
| refKind | input | 3 | access kind, encoded as in R4 |
| refFlavor | input | 3 | speculation flavor, encoded as in R3 and R4 |
| pageAttr | input | 2 | 0 write-back, 1 uncacheable, 2 NaT page, 3 uncacheable |
| wideOk | input | 1 | 10-byte accesses to non-write-back pages are supported |
| lowerFault | input | LOWER_W | lower-priority fault flags from a neighbouring check |
| deferMask | input | LOWER_W | lower-priority faults a speculative reference may defer |
| resValid | output | 1 | verdict valid |
| resCode | output | 3 | verdict code, see R11 |
| resProceed | output | 1 | the access goes ahead |
| resNatWrite | output | 1 | write the not-a-value indicator to the target |
| resSideEffect | output | 1 | perform side effects such as post-increment |

## Verification
The bench concentrates on the places where the flavor reverses the verdict. It drives speculative 10-byte float loads to uncacheable pages with wideOk at both values; a design that honoured the option bit here would raise code 3 where a deferral is required. It sends a normal 10-byte load to a NaT page with wideOk=0; a swapped priority would report code 3 instead of code 2. It sends stores and exchanges carrying speculative flavor values; a design that decoded the flavor for every kind would wrongly defer them. It also sends speculative references whose lower-fault flags are only partly covered by deferMask; a design that tested any mask bit rather than every flagged bit would defer when it must fault. Random traffic compares every verdict and every flag against a bench model.

// File: rtl/memAttrPkg.sv
package memAttrPkg;
  localparam int KIND_W   = 3;
  localparam int FLAVOR_W = 3;
  localparam int ATTR_W   = 2;
  localparam int CODE_W   = 3;

  localparam logic [KIND_W-1:0] KIND_FETCH = 3'd0;
  localparam logic [KIND_W-1:0] KIND_LOAD  = 3'd1;
  localparam logic [KIND_W-1:0] KIND_STORE = 3'd2;
  localparam logic [KIND_W-1:0] KIND_SEMA  = 3'd3;
  localparam logic [KIND_W-1:0] KIND_XCHG  = 3'd4;
  localparam logic [KIND_W-1:0] KIND_CMPX  = 3'd5;
  localparam logic [KIND_W-1:0] KIND_LD10  = 3'd6;
  localparam logic [KIND_W-1:0] KIND_ST10  = 3'd7;

  localparam logic [FLAVOR_W-1:0] FLV_SPEC    = 3'd3;
  localparam logic [FLAVOR_W-1:0] FLV_SPECADV = 3'd4;

  localparam logic [ATTR_W-1:0] ATTR_WB  = 2'd0;
  localparam logic [ATTR_W-1:0] ATTR_NAT = 2'd2;

  localparam logic [CODE_W-1:0] CODE_GO    = 3'd0;
  localparam logic [CODE_W-1:0] CODE_DEFER = 3'd1;
  localparam logic [CODE_W-1:0] CODE_NATC  = 3'd2;
  localparam logic [CODE_W-1:0] CODE_UNSUP = 3'd3;
  localparam logic [CODE_W-1:0] CODE_LOWER = 3'd4;

  // strobes from the classifier to the verdict register stage
  typedef struct packed {
    logic live;       // a reference is present
    logic natHit;     // page is a NaT page
    logic specRef;    // speculative flavor on a kind that has flavors
    logic unsupHit;   // width or atomic not supported on this page
    logic lowerAny;   // some lower-priority fault flagged
    logic lowerOpen;  // some flagged lower fault is not deferrable
  } strobeT;
endpackage

// File: rtl/accCtrl.sv
module accCtrl
  import memAttrPkg::*;
#(
  parameter int LOWER_W = 4
) (
  input  logic                refValid,
  input  logic [KIND_W-1:0]   refKind,
  input  logic [FLAVOR_W-1:0] refFlavor,
  input  logic [ATTR_W-1:0]   pageAttr,
  input  logic                wideOk,
  input  logic [LOWER_W-1:0]  lowerFault,
  input  logic [LOWER_W-1:0]  deferMask,
  output strobeT              stb
);
  logic hasFlavor;
  logic specFlavor;
  logic isWide;
  logic isAtomic;
  logic pageWb;
  logic pageNat;

  always_comb begin
    hasFlavor  = (refKind == KIND_LOAD) || (refKind == KIND_LD10);
    specFlavor = (refFlavor == FLV_SPEC) || (refFlavor == FLV_SPECADV);
    isWide     = (refKind == KIND_LD10) || (refKind == KIND_ST10);
    isAtomic   = (refKind == KIND_XCHG) || (refKind == KIND_CMPX);
    pageWb     = (pageAttr == ATTR_WB);
    pageNat    = (pageAttr == ATTR_NAT);

    stb.live    = refValid;
    stb.natHit  = pageNat;
    stb.specRef = hasFlavor && specFlavor;
    // speculative wide loads defer on any non-write-back page; others follow the option bit
    stb.unsupHit = (!pageWb && !pageNat) &&
                   ((isWide && (stb.specRef || !wideOk)) || isAtomic);
    stb.lowerAny  = |lowerFault;
    stb.lowerOpen = |(lowerFault & ~deferMask);
  end
endmodule

// File: rtl/accPath.sv
module accPath
  import memAttrPkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobeT            stb,
  output logic              resValid,
  output logic [CODE_W-1:0] resCode,
  output logic              resProceed,
  output logic              resNatWrite,
  output logic              resSideEffect
);
  logic [CODE_W-1:0] nextCode;
  logic [CODE_W-1:0] specLower;

  always_comb begin
    specLower = stb.lowerOpen ? CODE_LOWER : CODE_DEFER;
    if (stb.natHit)
      nextCode = stb.specRef ? specLower : CODE_NATC;
    else if (stb.unsupHit)
      nextCode = stb.specRef ? CODE_DEFER : CODE_UNSUP;
    else if (stb.lowerAny)
      nextCode = stb.specRef ? specLower : CODE_LOWER;
    else
      nextCode = CODE_GO;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resValid      <= 1'b0;
      resCode       <= CODE_GO;
      resProceed    <= 1'b0;
      resNatWrite   <= 1'b0;
      resSideEffect <= 1'b0;
    end else begin
      resValid      <= stb.live;
      resCode       <= stb.live ? nextCode : CODE_GO;
      resProceed    <= stb.live && (nextCode == CODE_GO);
      resNatWrite   <= stb.live && (nextCode == CODE_DEFER);
      resSideEffect <= stb.live && ((nextCode == CODE_GO) || (nextCode == CODE_DEFER));
    end
  end
endmodule

// File: rtl/memAttrChecker.sv
module memAttrChecker
  import memAttrPkg::*;
#(
  parameter int LOWER_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                refValid,
  input  logic [KIND_W-1:0]   refKind,
  input  logic [FLAVOR_W-1:0] refFlavor,
  input  logic [ATTR_W-1:0]   pageAttr,
  input  logic                wideOk,
  input  logic [LOWER_W-1:0]  lowerFault,
  input  logic [LOWER_W-1:0]  deferMask,
  output logic                resValid,
  output logic [CODE_W-1:0]   resCode,
  output logic                resProceed,
  output logic                resNatWrite,
  output logic                resSideEffect
);
  strobeT stb;

  accCtrl #(.LOWER_W(LOWER_W)) u_ctrl (
    .refValid(refValid), .refKind(refKind), .refFlavor(refFlavor),
    .pageAttr(pageAttr), .wideOk(wideOk), .lowerFault(lowerFault),
    .deferMask(deferMask), .stb(stb)
  );

  accPath u_path (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .resValid(resValid), .resCode(resCode), .resProceed(resProceed),
    .resNatWrite(resNatWrite), .resSideEffect(resSideEffect)
  );
endmodule

// File: rtl/memAttrCheck.sv
module memAttrCheck
  import memAttrPkg::*;
#(
  parameter int LOWER_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                refValid,
  input logic [KIND_W-1:0]   refKind,
  input logic [FLAVOR_W-1:0] refFlavor,
  input logic [ATTR_W-1:0]   pageAttr,
  input logic                wideOk,
  input logic [LOWER_W-1:0]  lowerFault,
  input logic [LOWER_W-1:0]  deferMask,
  input logic                resValid,
  input logic [CODE_W-1:0]   resCode,
  input logic                resProceed,
  input logic                resNatWrite,
  input logic                resSideEffect
);
  logic specIn;
  assign specIn = ((refKind == 3'd1) || (refKind == 3'd6)) &&
                  ((refFlavor == 3'd3) || (refFlavor == 3'd4));

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !refValid |=> (!resValid && resCode == 3'd0));

  assert_nat_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (refValid && pageAttr == 2'd2 && !specIn) |=> (resCode == 3'd2 && !resSideEffect));

  assert_nat_defer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (refValid && pageAttr == 2'd2 && specIn && (lowerFault & ~deferMask) == '0)
      |=> (resCode == 3'd1 && resNatWrite && resSideEffect));

  assert_wide_spec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (refValid && refKind == 3'd6 && specIn && pageAttr != 2'd0) |=> (resCode == 3'd1 || resCode == 3'd4));

  assert_atomic_uc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (refValid && (refKind == 3'd4 || refKind == 3'd5) && (pageAttr == 2'd1 || pageAttr == 2'd3))
      |=> resCode == 3'd3);

  assert_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |-> ($countones({resProceed, resNatWrite}) <= 1 &&
                  resSideEffect == (resProceed || resNatWrite)));

  assert_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    refValid |=> resValid);
endmodule

bind memAttrChecker memAttrCheck #(.LOWER_W(LOWER_W)) u_check (
  .clk(clk), .rst_n(rst_n), .refValid(refValid), .refKind(refKind),
  .refFlavor(refFlavor), .pageAttr(pageAttr), .wideOk(wideOk),
  .lowerFault(lowerFault), .deferMask(deferMask), .resValid(resValid),
  .resCode(resCode), .resProceed(resProceed), .resNatWrite(resNatWrite),
  .resSideEffect(resSideEffect)
);

// File: tb/memAttrChecker_bench.sv
`timescale 1ns/1ps
module memAttrChecker_bench;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic refValid = 1'b0;
  logic [2:0] refKind = '0;
  logic [2:0] refFlavor = '0;
  logic [1:0] pageAttr = '0;
  logic wideOk = 1'b0;
  logic [LW-1:0] lowerFault = '0;
  logic [LW-1:0] deferMask = '0;
  logic resValid;
  logic [2:0] resCode;
  logic resProceed, resNatWrite, resSideEffect;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  memAttrChecker #(.LOWER_W(LW)) u_memAttrChecker (
    .clk(clk), .rst_n(rst_n), .refValid(refValid), .refKind(refKind),
    .refFlavor(refFlavor), .pageAttr(pageAttr), .wideOk(wideOk),
    .lowerFault(lowerFault), .deferMask(deferMask), .resValid(resValid),
    .resCode(resCode), .resProceed(resProceed), .resNatWrite(resNatWrite),
    .resSideEffect(resSideEffect)
  );

  // bench model of the verdict, written from the requirements
  function automatic logic [2:0] model(input logic [2:0] k, input logic [2:0] f,
                                       input logic [1:0] a, input logic w,
                                       input logic [LW-1:0] lf, input logic [LW-1:0] dm);
    bit spec = (k == 3'd1 || k == 3'd6) && (f == 3'd3 || f == 3'd4);
    bit nat = (a == 2'd2);
    bit wb = (a == 2'd0);
    bit open = (lf & ~dm) != '0;
    if (nat) return spec ? (open ? 3'd4 : 3'd1) : 3'd2;
    if (!wb && (k == 3'd6 || k == 3'd7)) begin
      if (spec) return 3'd1;
      if (!w) return 3'd3;
    end
    if (!wb && (k == 3'd4 || k == 3'd5)) return 3'd3;
    if (lf != '0) return spec ? (open ? 3'd4 : 3'd1) : 3'd4;
    return 3'd0;
  endfunction

  task automatic check(input string req, input logic [2:0] gotCode, input logic [2:0] expCode,
                       input logic [3:0] gotFlags, input logic [3:0] expFlags);
    checks++;
    if (gotCode !== expCode || gotFlags !== expFlags) begin
      errors++;
      $display("FAIL %s code=%0d flags=%b expected code=%0d flags=%b",
               req, gotCode, gotFlags, expCode, expFlags);
    end
  endtask

  // present one reference at the falling edge, check its verdict after the next rising edge
  task automatic send(input string req, input logic v, input logic [2:0] k, input logic [2:0] f,
                      input logic [1:0] a, input logic w,
                      input logic [LW-1:0] lf, input logic [LW-1:0] dm);
    logic [2:0] e;
    @(negedge clk);
    refValid = v; refKind = k; refFlavor = f; pageAttr = a;
    wideOk = w; lowerFault = lf; deferMask = dm;
    e = v ? model(k, f, a, w, lf, dm) : 3'd0;
    @(posedge clk);
    #1;
    check(req, resCode, e, {resValid, resProceed, resNatWrite, resSideEffect},
          {v, v && e == 3'd0, v && e == 3'd1, v && (e == 3'd0 || e == 3'd1)});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", resCode, 3'd0, {resValid, resProceed, resNatWrite, resSideEffect}, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 after reset", resCode, 3'd0, {resValid, resProceed, resNatWrite, resSideEffect}, 4'b0000);

    send("R2 idle", 0, 3'd1, 3'd0, 2'd2, 0, '0, '0);
    send("R2 plain load", 1, 3'd1, 3'd0, 2'd0, 0, '0, '0);
    send("R3 spec load NaT", 1, 3'd1, 3'd3, 2'd2, 0, '0, '0);
    send("R3 specadv wide load NaT", 1, 3'd6, 3'd4, 2'd2, 0, '0, '0);
    send("R4 fetch NaT", 1, 3'd0, 3'd0, 2'd2, 1, '0, '0);
    send("R4 advanced load NaT", 1, 3'd1, 3'd1, 2'd2, 0, '0, '0);
    send("R4 cmpxchg NaT", 1, 3'd5, 3'd0, 2'd2, 0, '0, '0);
    send("R5 wide store UC no support", 1, 3'd7, 3'd0, 2'd1, 0, '0, '0);
    send("R5 check wide load UC supported", 1, 3'd6, 3'd2, 2'd1, 1, '0, '0);
    send("R6 spec wide load UC no support", 1, 3'd6, 3'd3, 2'd1, 0, '0, '0);
    send("R6 spec wide load UC supported", 1, 3'd6, 3'd3, 2'd3, 1, '0, '0);
    send("R7 xchg UC supported", 1, 3'd4, 3'd0, 2'd1, 1, '0, '0);
    send("R7 xchg WB", 1, 3'd4, 3'd0, 2'd0, 0, '0, '0);
    send("R8 wide load NaT unsupported", 1, 3'd6, 3'd0, 2'd2, 0, '0, '0);
    send("R8 NaT over lower fault", 1, 3'd2, 3'd0, 2'd2, 0, 4'b0001, 4'b1111);
    send("R9 nonspec lower fault", 1, 3'd1, 3'd0, 2'd0, 0, 4'b0100, 4'b1111);
    send("R9 spec lower partly masked", 1, 3'd1, 3'd4, 2'd0, 0, 4'b0110, 4'b0010);
    send("R9 spec lower fully masked", 1, 3'd1, 3'd3, 2'd0, 0, 4'b0110, 4'b0110);
    send("R9 spec NaT lower unmasked", 1, 3'd1, 3'd3, 2'd2, 0, 4'b1000, 4'b0000);
    send("R10 store spec flavor NaT", 1, 3'd2, 3'd3, 2'd2, 0, '0, '0);
    send("R10 load flavor 6 NaT", 1, 3'd1, 3'd6, 2'd2, 0, '0, '0);
    send("R10 attr 3 cmpxchg", 1, 3'd5, 3'd0, 2'd3, 0, '0, '0);
    send("R2 idle again", 0, 3'd0, 3'd0, 2'd0, 0, '0, '0);

    for (int i = 0; i < 4000; i++) begin
      logic [LW-1:0] lf;
      lf = ($urandom % 4 == 0) ? LW'($urandom) : '0;
      send("R11 random", ($urandom % 8) != 0, 3'($urandom), 3'($urandom),
           2'($urandom), 1'($urandom), lf, LW'($urandom));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule